// File: doc/BRIEF.md
# Debug Breakpoint Unit

This block sits beside a small processor core and watches three streams: the address of the instruction that will execute next, the data-memory bus and the frame-memory bus. When a configured break condition is met and debugging is enabled, it raises a halt request for the core. The request is held, and a cause register shows every source that matched in the cycle that fired. The debugger owns a small register write port. Through it the debugger programs the compare values and the control word, and it clears a pending halt by writing the cause register.

Two program-address comparators are dedicated. Two more are combined slots. A 3-bit mode field gives each combined slot a program or data role, or fuses the two slots into one masked range match. In a range match slot 0 holds the address and slot 1 holds the mask. A frame-memory comparator, a break-on-non-sequential-fetch trigger and a single-step trigger work alongside these, whatever the mode.

Program matches are tested against the next-PC bus when an instruction retires. The halt therefore lands before the matched instruction runs.

Top module: `dbg_break_unit`

## Requirements
- R1: After a synchronous active-low reset, `halt_req` is 0, `break_cause` is 0 and every control bit is 0.
- R2: A halt can only be raised when control bit 0 (link enable) and control bit 1 (debug enable) are both 1. With either bit at 0, no match sets `halt_req`.
- R3: When `retire` is 1 and `pc_next` equals the value in register 1 (or register 2), with control bit 4 (or bit 5) set, `halt_req` and cause bit 0 (or bit 1) are 1 after the next clock edge.
- R4: Mode field (control bits 11:9) selects the roles of combined slots 0 and 1: 0 gives program/program, 1 gives program/data, 2 gives data/data. Control bits 6 and 7 enable the slots. Register 3 holds slot 0's value and register 4 holds slot 1's value. Hits set cause bits 2 and 3. A slot in one role ignores the other space.
- R5: In mode 3, a retire with `(pc_next & reg4) == (reg3 & reg4)` and control bit 6 set raises a halt with cause bit 2.
- R6: In mode 4, a data access with `(d_addr & reg4) == (reg3 & reg4)` raises a halt with cause bit 2. The access must be a read with control bit 12 set or a write with control bit 13 set.
- R7: A single data match counts only for the strobe whose enable is set. Slot 0 uses control bit 12 for reads and bit 13 for writes. Slot 1 uses control bit 14 for reads and bit 15 for writes.
- R8: With control bit 8 set, an `f_acc` cycle whose `f_addr` equals register 5 raises a halt with cause bit 4, in every mode.
- R9: With control bit 2 set, a retire with `pc_nonseq` at 1 raises a halt with cause bit 5. A sequential retire does not.
- R10: With control bit 3 set, any retire raises a halt with cause bit 6. Cycles without a retire do not.
- R11: Once raised, `halt_req` and `break_cause` hold. They clear only on a write to register 6. That clear wins over a match in the same cycle.
- R12: Mode values 5, 6 and 7 disable both combined slots.
- R13: `break_cause` records every source that matched in the cycle that raised the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_next | input | PC_W | Address of the instruction to execute next |
| pc_nonseq | input | 1 | Next fetch is not sequential (jump, call, return, interrupt) |
| retire | input | 1 | One instruction retires this cycle |
| d_addr | input | DA_W | Data-memory address |
| d_rd | input | 1 | Data read strobe |
| d_wr | input | 1 | Data write strobe |
| f_addr | input | FA_W | Frame-memory address |
| f_acc | input | 1 | Frame-memory access strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select (0 control, 1-2 program, 3-4 combined, 5 frame, 6 cause clear) |
| cfg_wdata | input | CFG_W | Configuration write data |
| halt_req | output | 1 | Registered, sticky halt request |
| break_cause | output | 7 | Cause bits: 0/1 program, 2/3 combined, 4 frame, 5 flow, 6 step |

## Verification
The assertions assume a few things about the inputs. The strobes are never X outside reset. A configuration write lands one cycle before the bus activity it governs. `retire` stands for exactly one instruction per cycle. The stimulus keeps to these by changing inputs only on falling edges and issuing each configuration write as its own cycle. The one exception is a deliberate clear-with-hit cycle that tests priority. A behavioural model follows the same contract and is compared against the outputs every cycle.

// File: rtl/dbg_break_pkg.sv
// Shared types for the debug breakpoint unit: register selects, the control
// word layout, cause bit positions and the combined-slot role decode.
// Assumes the control word is 16 bits wide and sits in the low bits of write data.
package dbg_break_pkg;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_PC0   = 3'd1;
    localparam logic [2:0] REG_PC1   = 3'd2;
    localparam logic [2:0] REG_CMB0  = 3'd3;
    localparam logic [2:0] REG_CMB1  = 3'd4;
    localparam logic [2:0] REG_FRM   = 3'd5;
    localparam logic [2:0] REG_CAUSE = 3'd6;

    localparam int CTRL_W    = 16;
    localparam int NUM_CAUSE = 7;
    localparam int CAUSE_PC0  = 0;
    localparam int CAUSE_PC1  = 1;
    localparam int CAUSE_CMB0 = 2;
    localparam int CAUSE_CMB1 = 3;
    localparam int CAUSE_FRM  = 4;
    localparam int CAUSE_FLOW = 5;
    localparam int CAUSE_STEP = 6;

    localparam logic [2:0] MODE_LAST_LEGAL = 3'd4;

    // Control word, MSB first.
    typedef struct packed {
        logic       c1_wr;
        logic       c1_rd;
        logic       c0_wr;
        logic       c0_rd;
        logic [2:0] mode;
        logic       frm_en;
        logic       c1_en;
        logic       c0_en;
        logic       pc1_en;
        logic       pc0_en;
        logic       step_en;
        logic       flow_en;
        logic       dbg_en;
        logic       link_en;
    } ctrl_t;

    typedef enum logic [2:0] {
        ROLE_OFF,
        ROLE_PROG,
        ROLE_DATA,
        ROLE_PROG_RANGE,
        ROLE_DATA_RANGE
    } role_t;

    // Role of combined slot 0 or 1 for a mode value; illegal modes switch both off.
    function automatic role_t slot_role(input logic [2:0] mode, input int slot);
        role_t r;
        case (mode)
            3'd0:    r = ROLE_PROG;
            3'd1:    r = (slot == 0) ? ROLE_PROG : ROLE_DATA;
            3'd2:    r = ROLE_DATA;
            3'd3:    r = (slot == 0) ? ROLE_PROG_RANGE : ROLE_OFF;
            3'd4:    r = (slot == 0) ? ROLE_DATA_RANGE : ROLE_OFF;
            default: r = ROLE_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbg_addr_match.sv
// Masked address equality: hit when every bit selected by mask agrees
// between probe and ref_val. A single-address compare passes an all-ones mask.
// Purely combinational; no assumptions on inputs.
module dbg_addr_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] probe,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] mask,
    output logic         hit
);
    // Compare only the masked bit positions.
    always_comb begin
        hit = (((probe ^ ref_val) & mask) == '0);
    end
endmodule

// File: rtl/dbg_break_cfg.sv
// Configuration registers of the breakpoint unit. Holds the control word,
// two program compare values, two combined-slot values and the frame compare
// value. A write to the cause select produces a one-cycle clear pulse.
// Assumes PC_W, CW and FA_W do not exceed CFG_W, and CFG_W >= 16.
module dbg_break_cfg
    import dbg_break_pkg::*;
#(
    parameter int CFG_W = 16,
    parameter int PC_W  = 16,
    parameter int CW    = 16,
    parameter int FA_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output ctrl_t                ctrl,
    output logic [1:0][PC_W-1:0] pc_val,
    output logic [1:0][CW-1:0]   cmb_val,
    output logic [FA_W-1:0]      frm_val,
    output logic                 clr_req
);
    // Register file update on debugger writes; everything resets to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            pc_val  <= '0;
            cmb_val <= '0;
            frm_val <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL: ctrl       <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                REG_PC0:  pc_val[0]  <= cfg_wdata[PC_W-1:0];
                REG_PC1:  pc_val[1]  <= cfg_wdata[PC_W-1:0];
                REG_CMB0: cmb_val[0] <= cfg_wdata[CW-1:0];
                REG_CMB1: cmb_val[1] <= cfg_wdata[CW-1:0];
                REG_FRM:  frm_val    <= cfg_wdata[FA_W-1:0];
                default:  ;
            endcase
        end
    end

    // Clear request for the halt/cause state, same cycle as the write.
    always_comb begin
        clr_req = cfg_we && (cfg_addr == REG_CAUSE);
    end
endmodule

// File: rtl/dbg_break_unit.sv
// Debug breakpoint unit top. Combines two dedicated program comparators,
// two role-configurable combined comparators (single or fused into a masked
// range), one frame comparator and the flow-change and single-step triggers
// into a sticky halt request with a cause register.
// Assumes one retire per cycle at most and that pc_next is valid with retire.
module dbg_break_unit
    import dbg_break_pkg::*;
#(
    parameter int CFG_W = 16,
    parameter int PC_W  = 16,
    parameter int DA_W  = 16,
    parameter int FA_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_W-1:0]      pc_next,
    input  logic                 pc_nonseq,
    input  logic                 retire,
    input  logic [DA_W-1:0]      d_addr,
    input  logic                 d_rd,
    input  logic                 d_wr,
    input  logic [FA_W-1:0]      f_addr,
    input  logic                 f_acc,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic                 halt_req,
    output logic [NUM_CAUSE-1:0] break_cause
);
    localparam int CW = (PC_W > DA_W) ? PC_W : DA_W;

    ctrl_t                ctrl;
    logic [1:0][PC_W-1:0] pc_val;
    logic [1:0][CW-1:0]   cmb_val;
    logic [FA_W-1:0]      frm_val;
    logic                 clr_req;

    logic [1:0]           pc_hit;
    logic [1:0]           cmb_hit;
    logic                 frm_match;
    logic                 frm_hit;
    logic                 flow_hit;
    logic                 step_hit;
    logic                 gate_en;
    logic [NUM_CAUSE-1:0] hits;
    logic [CW-1:0]        pc_ext;
    logic [CW-1:0]        da_ext;
    logic                 halt_q;
    logic [NUM_CAUSE-1:0] cause_q;

    dbg_break_cfg #(
        .CFG_W (CFG_W),
        .PC_W  (PC_W),
        .CW    (CW),
        .FA_W  (FA_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .pc_val    (pc_val),
        .cmb_val   (cmb_val),
        .frm_val   (frm_val),
        .clr_req   (clr_req)
    );

    // Widen both address spaces to the shared comparator width.
    always_comb begin
        pc_ext = CW'(pc_next);
        da_ext = CW'(d_addr);
    end

    // Dedicated program-address comparators.
    for (genvar p = 0; p < 2; p++) begin : g_pc
        logic match;
        logic en;
        dbg_addr_match #(.W(PC_W)) u_match (
            .probe   (pc_next),
            .ref_val (pc_val[p]),
            .mask    ({PC_W{1'b1}}),
            .hit     (match)
        );
        // Per-comparator enable and retire qualification.
        always_comb begin
            en        = (p == 0) ? ctrl.pc0_en : ctrl.pc1_en;
            pc_hit[p] = en && retire && match;
        end
    end

    // Combined comparators; role and mask follow the mode field.
    for (genvar s = 0; s < 2; s++) begin : g_cmb
        role_t         role;
        logic          is_prog;
        logic          is_data;
        logic          en;
        logic          rd_ok;
        logic          wr_ok;
        logic [CW-1:0] probe;
        logic [CW-1:0] msk;
        logic          match;

        // Decode role, pick the probed bus and the mask for this slot.
        always_comb begin
            role    = slot_role(ctrl.mode, s);
            is_prog = (role == ROLE_PROG) || (role == ROLE_PROG_RANGE);
            is_data = (role == ROLE_DATA) || (role == ROLE_DATA_RANGE);
            probe   = is_prog ? pc_ext : da_ext;
            msk     = ((role == ROLE_PROG_RANGE) || (role == ROLE_DATA_RANGE))
                      ? cmb_val[1] : {CW{1'b1}};
            en      = (s == 0) ? ctrl.c0_en : ctrl.c1_en;
            rd_ok   = (s == 0) ? ctrl.c0_rd : ctrl.c1_rd;
            wr_ok   = (s == 0) ? ctrl.c0_wr : ctrl.c1_wr;
        end

        dbg_addr_match #(.W(CW)) u_match (
            .probe   (probe),
            .ref_val (cmb_val[s]),
            .mask    (msk),
            .hit     (match)
        );

        // Qualify the match by the strobe belonging to the slot's space.
        always_comb begin
            cmb_hit[s] = en && match &&
                         ((is_prog && retire) ||
                          (is_data && ((d_rd && rd_ok) || (d_wr && wr_ok))));
        end
    end

    dbg_addr_match #(.W(FA_W)) u_frm (
        .probe   (f_addr),
        .ref_val (frm_val),
        .mask    ({FA_W{1'b1}}),
        .hit     (frm_match)
    );

    // Frame, flow-change and single-step triggers, plus the global gate.
    always_comb begin
        frm_hit  = ctrl.frm_en && f_acc && frm_match;
        flow_hit = ctrl.flow_en && retire && pc_nonseq;
        step_hit = ctrl.step_en && retire;
        gate_en  = ctrl.link_en && ctrl.dbg_en;
        hits = '0;
        hits[CAUSE_PC0]  = pc_hit[0];
        hits[CAUSE_PC1]  = pc_hit[1];
        hits[CAUSE_CMB0] = cmb_hit[0];
        hits[CAUSE_CMB1] = cmb_hit[1];
        hits[CAUSE_FRM]  = frm_hit;
        hits[CAUSE_FLOW] = flow_hit;
        hits[CAUSE_STEP] = step_hit;
    end

    // Sticky halt and cause capture; a clear write wins over a same-cycle hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q  <= 1'b0;
            cause_q <= '0;
        end else if (clr_req) begin
            halt_q  <= 1'b0;
            cause_q <= '0;
        end else if (!halt_q && gate_en && (hits != '0)) begin
            halt_q  <= 1'b1;
            cause_q <= hits;
        end
    end

    assign halt_req    = halt_q;
    assign break_cause = cause_q;

    assert_halt_needs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_q) |-> $past(gate_en));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !clr_req) |=> (halt_q && $stable(cause_q)));

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!halt_q && (cause_q == '0)));

    assert_illegal_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode > MODE_LAST_LEGAL) |-> (cmb_hit == 2'b00));

    assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && ctrl.step_en && retire && !halt_q && !clr_req)
        |=> (halt_q && cause_q[CAUSE_STEP]));

    assert_cause_present_R13: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |-> (cause_q != '0));

    assert_cause_onehot_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode == 3'd3) |-> !cmb_hit[1]);

endmodule

// File: tb/dbg_break_unit_test.sv
// Bench for the breakpoint unit: a behavioural model predicts halt and cause
// every cycle; directed scenarios add explicit per-requirement expectations.
module dbg_break_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_next = '0;
    logic        pc_nonseq = 1'b0;
    logic        retire = 1'b0;
    logic [15:0] d_addr = '0;
    logic        d_rd = 1'b0;
    logic        d_wr = 1'b0;
    logic [11:0] f_addr = '0;
    logic        f_acc = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        halt_req;
    logic [6:0]  break_cause;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Model state
    logic [15:0] m_ctrl, m_p0, m_p1, m_c0, m_c1;
    logic [11:0] m_f;
    logic        m_halt;
    logic [6:0]  m_stat;

    always #5 clk = ~clk;

    dbg_break_unit uut (
        .clk(clk), .rst_n(rst_n), .pc_next(pc_next), .pc_nonseq(pc_nonseq),
        .retire(retire), .d_addr(d_addr), .d_rd(d_rd), .d_wr(d_wr),
        .f_addr(f_addr), .f_acc(f_acc), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .halt_req(halt_req), .break_cause(break_cause)
    );

    function automatic logic data_ok(input logic rd_en, input logic wr_en);
        return (d_rd && rd_en) || (d_wr && wr_en);
    endfunction

    // Behavioural prediction of this cycle's break sources.
    function automatic logic [6:0] model_hits();
        logic [6:0] h = '0;
        int mode = int'(m_ctrl[11:9]);
        if (retire && m_ctrl[4] && pc_next == m_p0) h[0] = 1'b1;
        if (retire && m_ctrl[5] && pc_next == m_p1) h[1] = 1'b1;
        if (mode == 0) begin
            if (m_ctrl[6] && retire && pc_next == m_c0) h[2] = 1'b1;
            if (m_ctrl[7] && retire && pc_next == m_c1) h[3] = 1'b1;
        end else if (mode == 1) begin
            if (m_ctrl[6] && retire && pc_next == m_c0) h[2] = 1'b1;
            if (m_ctrl[7] && d_addr == m_c1 && data_ok(m_ctrl[14], m_ctrl[15])) h[3] = 1'b1;
        end else if (mode == 2) begin
            if (m_ctrl[6] && d_addr == m_c0 && data_ok(m_ctrl[12], m_ctrl[13])) h[2] = 1'b1;
            if (m_ctrl[7] && d_addr == m_c1 && data_ok(m_ctrl[14], m_ctrl[15])) h[3] = 1'b1;
        end else if (mode == 3) begin
            if (m_ctrl[6] && retire && (pc_next & m_c1) == (m_c0 & m_c1)) h[2] = 1'b1;
        end else if (mode == 4) begin
            if (m_ctrl[6] && (d_addr & m_c1) == (m_c0 & m_c1) &&
                data_ok(m_ctrl[12], m_ctrl[13])) h[2] = 1'b1;
        end
        if (m_ctrl[8] && f_acc && f_addr == m_f) h[4] = 1'b1;
        if (m_ctrl[2] && retire && pc_nonseq) h[5] = 1'b1;
        if (m_ctrl[3] && retire) h[6] = 1'b1;
        return h;
    endfunction

    task automatic model_reset();
        m_ctrl = '0; m_p0 = '0; m_p1 = '0; m_c0 = '0; m_c1 = '0; m_f = '0;
        m_halt = 1'b0; m_stat = '0;
    endtask

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic tick();
        logic [6:0] h;
        @(posedge clk);
        h = model_hits();
        if (cfg_we && cfg_addr == 3'd6) begin
            m_halt = 1'b0; m_stat = '0;
        end else if (!m_halt && m_ctrl[0] && m_ctrl[1] && h != '0) begin
            m_halt = 1'b1; m_stat = h;
        end
        if (cfg_we) begin
            case (cfg_addr)
                3'd0: m_ctrl = cfg_wdata;
                3'd1: m_p0 = cfg_wdata;
                3'd2: m_p1 = cfg_wdata;
                3'd3: m_c0 = cfg_wdata;
                3'd4: m_c1 = cfg_wdata;
                3'd5: m_f = cfg_wdata[11:0];
                default: ;
            endcase
        end
        @(negedge clk);
        checks++;
        if (halt_req !== m_halt || break_cause !== m_stat) begin
            errors++;
            $display("FAIL %s model: halt=%b cause=%b expected halt=%b cause=%b",
                     cur_req, halt_req, break_cause, m_halt, m_stat);
        end
    endtask

    task automatic expect_out(input logic h, input logic [6:0] s, input string req);
        checks++;
        if (halt_req !== h || break_cause !== s) begin
            errors++;
            $display("FAIL %s: halt=%b cause=%b expected halt=%b cause=%b",
                     req, halt_req, break_cause, h, s);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clr();
        wr(3'd6, 16'h0);
    endtask

    task automatic fetch(input logic [15:0] pc, input logic ns);
        retire = 1'b1; pc_next = pc; pc_nonseq = ns;
        tick();
        retire = 1'b0; pc_nonseq = 1'b0;
    endtask

    task automatic dacc(input logic [15:0] a, input logic rd, input logic wrs);
        d_addr = a; d_rd = rd; d_wr = wrs;
        tick();
        d_rd = 1'b0; d_wr = 1'b0;
    endtask

    task automatic facc(input logic [11:0] a);
        f_addr = a; f_acc = 1'b1;
        tick();
        f_acc = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run still active, expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        expect_out(1'b0, 7'h00, "R1");
        tick();

        cur_req = "R2";
        wr(3'd1, 16'h0040);
        wr(3'd0, 16'h0010);
        fetch(16'h0040, 1'b0);
        expect_out(1'b0, 7'h00, "R2 no enables");
        wr(3'd0, 16'h0011);
        fetch(16'h0040, 1'b0);
        expect_out(1'b0, 7'h00, "R2 link only");
        wr(3'd0, 16'h0012);
        fetch(16'h0040, 1'b0);
        expect_out(1'b0, 7'h00, "R2 debug only");

        cur_req = "R3";
        wr(3'd0, 16'h0013);
        fetch(16'h0041, 1'b0);
        expect_out(1'b0, 7'h00, "R3 miss");
        fetch(16'h0040, 1'b0);
        expect_out(1'b1, 7'h01, "R3 pc0");
        clr();
        expect_out(1'b0, 7'h00, "R11 clear");
        wr(3'd2, 16'h0100);
        wr(3'd0, 16'h0023);
        fetch(16'h0100, 1'b0);
        expect_out(1'b1, 7'h02, "R3 pc1");
        clr();

        cur_req = "R4";
        wr(3'd3, 16'h0200);
        wr(3'd4, 16'h0300);
        wr(3'd0, 16'h00C3);
        fetch(16'h0300, 1'b0);
        expect_out(1'b1, 7'h08, "R4 mode0 slot1");
        clr();
        fetch(16'h0200, 1'b0);
        expect_out(1'b1, 7'h04, "R4 mode0 slot0");
        clr();
        wr(3'd0, 16'h42C3);
        fetch(16'h0300, 1'b0);
        expect_out(1'b0, 7'h00, "R4 mode1 data slot ignores fetch");
        dacc(16'h0300, 1'b1, 1'b0);
        expect_out(1'b1, 7'h08, "R4 mode1 data read");
        clr();
        fetch(16'h0200, 1'b0);
        expect_out(1'b1, 7'h04, "R4 mode1 program slot");
        clr();

        cur_req = "R7";
        wr(3'd0, 16'h24C3);
        dacc(16'h0200, 1'b1, 1'b0);
        expect_out(1'b0, 7'h00, "R7 read not enabled");
        dacc(16'h0300, 1'b1, 1'b1);
        expect_out(1'b0, 7'h00, "R7 slot1 strobes disabled");
        fetch(16'h0200, 1'b0);
        expect_out(1'b0, 7'h00, "R4 mode2 ignores fetch");
        dacc(16'h0200, 1'b0, 1'b1);
        expect_out(1'b1, 7'h04, "R7 write enabled");
        clr();

        cur_req = "R5";
        wr(3'd3, 16'h1200);
        wr(3'd4, 16'hFF00);
        wr(3'd0, 16'h0643);
        fetch(16'h13AB, 1'b0);
        expect_out(1'b0, 7'h00, "R5 outside range");
        dacc(16'h12AB, 1'b1, 1'b1);
        expect_out(1'b0, 7'h00, "R5 data ignored");
        fetch(16'h12AB, 1'b0);
        expect_out(1'b1, 7'h04, "R5 inside range");
        clr();

        cur_req = "R6";
        wr(3'd0, 16'h1843);
        dacc(16'h1234, 1'b0, 1'b1);
        expect_out(1'b0, 7'h00, "R6 write not enabled");
        fetch(16'h1234, 1'b0);
        expect_out(1'b0, 7'h00, "R6 fetch ignored");
        dacc(16'h1299, 1'b1, 1'b0);
        expect_out(1'b1, 7'h04, "R6 read in range");
        clr();

        cur_req = "R12";
        wr(3'd3, 16'h0500);
        wr(3'd4, 16'h0500);
        for (int m = 5; m < 8; m++) begin
            wr(3'd0, 16'hF0C3 | 16'(m << 9));
            fetch(16'h0500, 1'b0);
            expect_out(1'b0, 7'h00, "R12 fetch in illegal mode");
            dacc(16'h0500, 1'b1, 1'b1);
            expect_out(1'b0, 7'h00, "R12 data in illegal mode");
        end

        cur_req = "R8";
        wr(3'd5, 16'h0ABC);
        wr(3'd0, 16'h0F03);
        facc(12'hABD);
        expect_out(1'b0, 7'h00, "R8 frame miss");
        facc(12'hABC);
        expect_out(1'b1, 7'h10, "R8 frame hit illegal mode");
        clr();
        wr(3'd0, 16'h0703);
        facc(12'hABC);
        expect_out(1'b1, 7'h10, "R8 frame hit range mode");
        clr();

        cur_req = "R9";
        wr(3'd0, 16'h0007);
        fetch(16'h0010, 1'b0);
        expect_out(1'b0, 7'h00, "R9 sequential");
        fetch(16'h0020, 1'b1);
        expect_out(1'b1, 7'h20, "R9 non-sequential");
        clr();

        cur_req = "R10";
        wr(3'd0, 16'h000B);
        tick();
        expect_out(1'b0, 7'h00, "R10 no retire");
        fetch(16'h0030, 1'b0);
        expect_out(1'b1, 7'h40, "R10 one retire");

        cur_req = "R11";
        wr(3'd1, 16'h0040);
        wr(3'd0, 16'h001B);
        fetch(16'h0040, 1'b1);
        expect_out(1'b1, 7'h40, "R11 cause frozen while halted");
        cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = '0;
        retire = 1'b1; pc_next = 16'h0040;
        tick();
        cfg_we = 1'b0; retire = 1'b0;
        expect_out(1'b0, 7'h00, "R11 clear beats hit");
        tick();
        expect_out(1'b0, 7'h00, "R11 stays clear");

        cur_req = "R13";
        wr(3'd0, 16'h001F);
        fetch(16'h0040, 1'b1);
        expect_out(1'b1, 7'h61, "R13 three sources");
        clr();
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule